// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block brings a device out of its low-power state and back to normal running. A one-cycle request arms it. At that moment the block captures the wake source selection, the exit mode and the PLL reference choice, and it holds those values until the sequence is finished. While asleep it switches off the regulator, oscillator and PLL enables and holds the port pins. It then watches a single wake pin, chosen from three serial receive inputs or two external interrupt inputs.

A low level on the chosen pin counts as a wake only if it lasts a minimum time. Shorter low pulses are filtered out. After a valid wake the block raises the enables in order and waits at each step: regulator settling, internal oscillator start-up (skipped when an external clock feeds the PLL), then PLL lock.

The captured mode bit selects the exit. On the reset exit the block requests a reset, drives the ports to their reset state and adds a flash-ready wait. On the fast exit the ports stay held and a single resume strobe lets the CPU continue where it stopped. Every wait is a down-counter whose length is derived at elaboration from a time in nanoseconds and the always-on reference clock frequency.

Top module: `pdwake_seq`

## Requirements
- R1: A `pd_req` pulse while running enters sleep. In sleep `reg_en`, `osc_en` and `pll_en` are 0 and `port_hold` is 1. A `pd_req` while any sleep or wake state is active is ignored.
- R2: With `cfg_src_rx`=1 the wake pin is `rx_pins[cfg_rx_sel]`, and code 3 selects `rx_pins[0]`. With `cfg_src_rx`=0 it is `int_pins[cfg_int_sel]`. Lows on all other pins have no effect.
- R3: A wake is accepted only after the selected pin has been low for FILT_NS worth of consecutive reference cycles (5 cycles at 50 MHz for 100 ns). A shorter low pulse is ignored, and the count restarts whenever the pin is high.
- R4: A wake first enables only the regulator, for exactly the regulator wait in cycles.
- R5: The internal oscillator phase (`reg_en` and `osc_en`, no `pll_en`) lasts exactly the oscillator wait. It is followed by the PLL wait with all three enables on.
- R6: With `cfg_ext_osc`=1 the oscillator phase is skipped and `osc_en` stays 0 for the whole wake sequence. The PLL wait follows the regulator wait directly.
- R7: With `cfg_wake_rst`=1, `port_rst` and `rst_req` are high from the wake event to the end of a flash-ready wait that follows the PLL wait. `port_hold` is 0 during that time and `cpu_resume` never pulses.
- R8: With `cfg_wake_rst`=0 there is no flash wait. `port_hold` stays 1 through the whole sequence, and `cpu_resume` is high for exactly one cycle, right after the PLL wait.
- R9: `irq_block` is 1 from sleep entry until the block is running again, so a wake event cannot raise an interrupt.
- R10: The source selects, mode bit and reference choice are captured at sleep entry. Changing them while asleep has no effect.
- R11: `rst_n` low returns the block to the running state immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| pd_req | input | 1 | One-cycle request to enter sleep |
| cfg_src_rx | input | 1 | 1: wake from a receive pin, 0: from an interrupt pin |
| cfg_rx_sel | input | 2 | Receive pin select (0..2, 3 acts as 0) |
| cfg_int_sel | input | 1 | Interrupt pin select |
| cfg_wake_rst | input | 1 | 1: reset exit, 0: fast resume exit |
| cfg_ext_osc | input | 1 | 1: external clock feeds the PLL, skip oscillator wait |
| rx_pins | input | 3 | Serial receive inputs, idle high |
| int_pins | input | 2 | External interrupt inputs, idle high |
| reg_en | output | 1 | Main regulator enable |
| osc_en | output | 1 | Internal oscillator enable |
| pll_en | output | 1 | PLL enable |
| port_hold | output | 1 | Keep port pins at their held values |
| port_rst | output | 1 | Force port pins to reset state |
| rst_req | output | 1 | Reset request for the rest of the chip |
| cpu_resume | output | 1 | One-cycle strobe to resume the CPU |
| irq_block | output | 1 | Suppress interrupt requests from the wake pin |

## Verification
A new sleep request can land in the same cycle as the `cpu_resume` strobe that ends a fast wake. The sequencer is then still leaving its resume state, so the request must be dropped, not re-arm sleep. The bench provokes this collision by watching for the strobe and driving `pd_req` high over the very edge that returns the block to running. It then checks that the regulator and PLL enables stay on and that `irq_block` stays low. A second overlap, a hardware reset arriving in the middle of the regulator wait, is judged straight after the reset edge, before any clock.

// File: rtl/pdwake_pkg.sv
package pdwake_pkg;

  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_REG, ST_OSC, ST_PLL, ST_FLASH, ST_RESUME
  } pdw_state_e;

  // cycles of a reference clock (kHz) covering a time in ns, rounded up, at least one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned khz);
    logic [63:0] prod;
    prod = 64'(ns) * 64'(khz);
    prod = (prod + 64'd999_999) / 64'd1_000_000;
    if (prod == 64'd0) prod = 64'd1;
    return prod[31:0];
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdw_wake_pick.sv
module pdw_wake_pick #(
  parameter int unsigned N_RX  = 3,
  parameter int unsigned N_INT = 2,
  localparam int unsigned RXW  = (N_RX  > 1) ? $clog2(N_RX)  : 1,
  localparam int unsigned INW  = (N_INT > 1) ? $clog2(N_INT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_rx,
  input  logic [RXW-1:0]   rx_sel,
  input  logic [INW-1:0]   int_sel,
  input  logic [N_RX-1:0]  rx_pins,
  input  logic [N_INT-1:0] int_pins,
  output logic             wake_lvl
);
  logic rx_lvl, int_lvl, raw_lvl;
  logic sync1;

  // out-of-range receive codes fall back to input 0 (R2)
  always_comb begin
    rx_lvl  = (32'(rx_sel) < N_RX)   ? rx_pins[rx_sel]   : rx_pins[0];
    int_lvl = (32'(int_sel) < N_INT) ? int_pins[int_sel] : int_pins[0];
    raw_lvl = src_rx ? rx_lvl : int_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= 1'b1;
      wake_lvl <= 1'b1;
    end else begin
      sync1    <= raw_lvl;
      wake_lvl <= sync1;
    end
  end
endmodule

// File: rtl/pdw_lowfilt.sv
module pdw_lowfilt #(
  parameter int unsigned FILT_CYC = 5,
  localparam int unsigned CW = $clog2(FILT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic lvl,
  output logic wake_evt
);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (!arm || lvl)                low_cnt <= '0;
    else if (low_cnt != CW'(FILT_CYC))   low_cnt <= low_cnt + 1'b1;
  end

  assign wake_evt = arm && !lvl && (low_cnt == CW'(FILT_CYC - 1));

  generate
    if (FILT_CYC >= 2) begin : g_chk
      p_evt_low_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> (!lvl && $past(!lvl) && $past(arm)));
    end
  endgenerate
endmodule

// File: rtl/pdw_fsm.sv
module pdw_fsm
  import pdwake_pkg::*;
#(
  parameter int unsigned REG_CYC   = 50,
  parameter int unsigned OSC_CYC   = 25,
  parameter int unsigned PLL_CYC   = 75,
  parameter int unsigned FLASH_CYC = 40,
  localparam int unsigned MAXC = max2(max2(REG_CYC, OSC_CYC), max2(PLL_CYC, FLASH_CYC)),
  localparam int unsigned CW   = $clog2(MAXC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req,
  input  logic       cfg_src_rx,
  input  logic [1:0] cfg_rx_sel,
  input  logic       cfg_int_sel,
  input  logic       cfg_wake_rst,
  input  logic       cfg_ext_osc,
  input  logic       wake_evt,
  output logic       src_rx_q,
  output logic [1:0] rx_sel_q,
  output logic       int_sel_q,
  output logic       arm,
  output logic       reg_en,
  output logic       osc_en,
  output logic       pll_en,
  output logic       port_hold,
  output logic       port_rst,
  output logic       rst_req,
  output logic       cpu_resume,
  output logic       irq_block
);
  pdw_state_e    state;
  logic [CW-1:0] cnt;
  logic          mode_q, ext_q;
  logic          wait_done;

  assign wait_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      cnt       <= '0;
      mode_q    <= 1'b0;
      ext_q     <= 1'b0;
      src_rx_q  <= 1'b0;
      rx_sel_q  <= '0;
      int_sel_q <= 1'b0;
    end else begin
      case (state)
        ST_RUN: if (pd_req) begin
          state     <= ST_SLEEP;
          mode_q    <= cfg_wake_rst;
          ext_q     <= cfg_ext_osc;
          src_rx_q  <= cfg_src_rx;
          rx_sel_q  <= cfg_rx_sel;
          int_sel_q <= cfg_int_sel;
        end
        ST_SLEEP: if (wake_evt) begin
          state <= ST_REG;
          cnt   <= CW'(REG_CYC - 1);
        end
        ST_REG: if (wait_done) begin
          if (ext_q) begin
            state <= ST_PLL;
            cnt   <= CW'(PLL_CYC - 1);
          end else begin
            state <= ST_OSC;
            cnt   <= CW'(OSC_CYC - 1);
          end
        end else cnt <= cnt - 1'b1;
        ST_OSC: if (wait_done) begin
          state <= ST_PLL;
          cnt   <= CW'(PLL_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_PLL: if (wait_done) begin
          if (mode_q) begin
            state <= ST_FLASH;
            cnt   <= CW'(FLASH_CYC - 1);
          end else state <= ST_RESUME;
        end else cnt <= cnt - 1'b1;
        ST_FLASH: if (wait_done) state <= ST_RUN;
                  else cnt <= cnt - 1'b1;
        default:  state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    reg_en     = 1'b1;
    osc_en     = 1'b1;
    pll_en     = 1'b1;
    port_hold  = 1'b0;
    port_rst   = 1'b0;
    rst_req    = 1'b0;
    cpu_resume = 1'b0;
    irq_block  = 1'b1;
    arm        = 1'b0;
    case (state)
      ST_RUN:   irq_block = 1'b0;
      ST_SLEEP: begin
        reg_en = 1'b0; osc_en = 1'b0; pll_en = 1'b0;
        port_hold = 1'b1; arm = 1'b1;
      end
      ST_REG: begin
        osc_en = 1'b0; pll_en = 1'b0;
        port_hold = !mode_q; port_rst = mode_q; rst_req = mode_q;
      end
      ST_OSC: begin
        pll_en = 1'b0;
        port_hold = !mode_q; port_rst = mode_q; rst_req = mode_q;
      end
      ST_PLL: begin
        osc_en = !ext_q;
        port_hold = !mode_q; port_rst = mode_q; rst_req = mode_q;
      end
      ST_FLASH: begin
        osc_en = !ext_q; port_rst = 1'b1; rst_req = 1'b1;
      end
      ST_RESUME: begin
        osc_en = !ext_q; port_hold = 1'b1; cpu_resume = 1'b1;
      end
      default: irq_block = 1'b0;
    endcase
  end

  p_wake_needs_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REG && $past(state) == ST_SLEEP) |-> $past(wake_evt));
  p_resume_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resume |=> !cpu_resume);
  p_resume_after_pll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resume |-> ($past(pll_en) && $past(irq_block) && !port_rst));
  p_hold_vs_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_hold && port_rst));
  p_no_int_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_block && ext_q && state != ST_SLEEP) |-> !osc_en);
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && $past(state) != ST_RUN) |-> ($stable(mode_q) && $stable(ext_q)));
endmodule

// File: rtl/pdwake_seq.sv
module pdwake_seq
  import pdwake_pkg::*;
#(
  parameter int unsigned REF_KHZ  = 50_000,
  parameter int unsigned FILT_NS  = 100,
  parameter int unsigned REG_NS   = 150_000,
  parameter int unsigned OSC_NS   = 500,
  parameter int unsigned PLL_NS   = 200_000,
  parameter int unsigned FLASH_NS = 160_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req,
  input  logic       cfg_src_rx,
  input  logic [1:0] cfg_rx_sel,
  input  logic       cfg_int_sel,
  input  logic       cfg_wake_rst,
  input  logic       cfg_ext_osc,
  input  logic [2:0] rx_pins,
  input  logic [1:0] int_pins,
  output logic       reg_en,
  output logic       osc_en,
  output logic       pll_en,
  output logic       port_hold,
  output logic       port_rst,
  output logic       rst_req,
  output logic       cpu_resume,
  output logic       irq_block
);
  localparam int unsigned FILT_CYC  = ns_to_cyc(FILT_NS,  REF_KHZ);
  localparam int unsigned REG_CYC   = ns_to_cyc(REG_NS,   REF_KHZ);
  localparam int unsigned OSC_CYC   = ns_to_cyc(OSC_NS,   REF_KHZ);
  localparam int unsigned PLL_CYC   = ns_to_cyc(PLL_NS,   REF_KHZ);
  localparam int unsigned FLASH_CYC = ns_to_cyc(FLASH_NS, REF_KHZ);

  logic       src_rx_q, int_sel_q, arm, wake_lvl, wake_evt;
  logic [1:0] rx_sel_q;

  pdw_wake_pick #(.N_RX(3), .N_INT(2)) u_pick (
    .clk(clk), .rst_n(rst_n), .src_rx(src_rx_q), .rx_sel(rx_sel_q),
    .int_sel(int_sel_q), .rx_pins(rx_pins), .int_pins(int_pins),
    .wake_lvl(wake_lvl)
  );

  pdw_lowfilt #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .lvl(wake_lvl), .wake_evt(wake_evt)
  );

  pdw_fsm #(
    .REG_CYC(REG_CYC), .OSC_CYC(OSC_CYC), .PLL_CYC(PLL_CYC), .FLASH_CYC(FLASH_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req),
    .cfg_src_rx(cfg_src_rx), .cfg_rx_sel(cfg_rx_sel), .cfg_int_sel(cfg_int_sel),
    .cfg_wake_rst(cfg_wake_rst), .cfg_ext_osc(cfg_ext_osc), .wake_evt(wake_evt),
    .src_rx_q(src_rx_q), .rx_sel_q(rx_sel_q), .int_sel_q(int_sel_q), .arm(arm),
    .reg_en(reg_en), .osc_en(osc_en), .pll_en(pll_en), .port_hold(port_hold),
    .port_rst(port_rst), .rst_req(rst_req), .cpu_resume(cpu_resume),
    .irq_block(irq_block)
  );

  p_sleep_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!irq_block) && $past(pd_req)) |-> (!reg_en && !pll_en && port_hold && irq_block));
endmodule

// File: tb/pdwake_seq_test.sv
`timescale 1ns/1ps
module pdwake_seq_test;
  // times at a 50 MHz reference: 20 ns per cycle
  localparam int FILT = 5;    // 100 ns
  localparam int TREG = 50;   // 1000 ns
  localparam int TOSC = 25;   // 500 ns
  localparam int TPLL = 75;   // 1500 ns
  localparam int TFL  = 40;   // 800 ns
  localparam int NV   = 8;

  // {src_rx, rx_sel[1:0], int_sel, mode_rst, ext_osc, wake_exp, pulse[7:0]}
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8},
    {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd8},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd8},
    {1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8},
    {1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5},
    {1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'd8},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
    {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, pd_req = 1'b0;
  logic cfg_src_rx = 1'b0, cfg_int_sel = 1'b0, cfg_wake_rst = 1'b0, cfg_ext_osc = 1'b0;
  logic [1:0] cfg_rx_sel = 2'd0;
  logic [2:0] rx_pins = 3'b111;
  logic [1:0] int_pins = 2'b11;
  logic reg_en, osc_en, pll_en, port_hold, port_rst, rst_req, cpu_resume, irq_block;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit mon_clr = 1'b0;
  int n_reg, n_osc, n_oscany, n_full, n_res, n_prst, n_rreq, n_nohold;

  always #10 clk = ~clk;

  pdwake_seq #(.REF_KHZ(50_000), .FILT_NS(100), .REG_NS(1000), .OSC_NS(500),
               .PLL_NS(1500), .FLASH_NS(800)) uut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .cfg_src_rx(cfg_src_rx),
    .cfg_rx_sel(cfg_rx_sel), .cfg_int_sel(cfg_int_sel), .cfg_wake_rst(cfg_wake_rst),
    .cfg_ext_osc(cfg_ext_osc), .rx_pins(rx_pins), .int_pins(int_pins),
    .reg_en(reg_en), .osc_en(osc_en), .pll_en(pll_en), .port_hold(port_hold),
    .port_rst(port_rst), .rst_req(rst_req), .cpu_resume(cpu_resume),
    .irq_block(irq_block)
  );

  // phase monitor, samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (mon_clr) begin
      n_reg = 0; n_osc = 0; n_oscany = 0; n_full = 0;
      n_res = 0; n_prst = 0; n_rreq = 0; n_nohold = 0;
    end else if (irq_block && (reg_en || pll_en || osc_en)) begin
      if (reg_en && !osc_en && !pll_en) n_reg++;
      if (osc_en && !pll_en)            n_osc++;
      if (osc_en)                       n_oscany++;
      if (pll_en)                       n_full++;
      if (cpu_resume)                   n_res++;
      if (port_rst)                     n_prst++;
      if (rst_req)                      n_rreq++;
      if (!port_hold)                   n_nohold++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic enter_sleep();
    @(negedge clk); pd_req = 1'b1;
    @(negedge clk); pd_req = 1'b0;
  endtask

  task automatic pin_low(input bit isrx, input int idx, input int n);
    @(negedge clk);
    if (isrx) rx_pins[idx] = 1'b0; else int_pins[idx] = 1'b0;
    cyc(n);
    rx_pins = 3'b111; int_pins = 2'b11;
  endtask

  task automatic wait_run();
    for (int i = 0; i < 2000 && irq_block; i++) @(negedge clk);
  endtask

  task automatic check_seq(input bit mode, input bit ext, input string tag);
    int oscx;
    oscx = ext ? 0 : TOSC;
    chk(!irq_block, {tag, " R9 back to running"}, irq_block, 0);
    chk(n_reg == TREG, {tag, " R4 regulator wait"}, n_reg, TREG);
    chk(n_osc == oscx, {tag, " R5 oscillator wait"}, n_osc, oscx);
    if (ext) chk(n_oscany == 0, {tag, " R6 osc_en kept low"}, n_oscany, 0);
    if (mode) begin
      chk(n_full == TPLL + TFL, {tag, " R7 pll plus flash wait"}, n_full, TPLL + TFL);
      chk(n_prst == TREG + oscx + TPLL + TFL, {tag, " R7 port_rst span"}, n_prst, TREG + oscx + TPLL + TFL);
      chk(n_rreq == n_prst, {tag, " R7 rst_req span"}, n_rreq, n_prst);
      chk(n_res == 0, {tag, " R7 no resume"}, n_res, 0);
    end else begin
      chk(n_full == TPLL + 1, {tag, " R8 pll wait then resume"}, n_full, TPLL + 1);
      chk(n_res == 1, {tag, " R8 single resume"}, n_res, 1);
      chk(n_prst == 0, {tag, " R8 no port reset"}, n_prst, 0);
      chk(n_nohold == 0, {tag, " R8 hold kept"}, n_nohold, 0);
    end
  endtask

  initial begin
    #(20 * 150_000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // reset state, R11
    chk(reg_en && osc_en && pll_en, "R11 reset enables on", {reg_en, osc_en, pll_en}, 7);
    chk(!port_hold && !port_rst && !rst_req && !cpu_resume && !irq_block,
        "R11 reset controls low", {port_hold, port_rst, rst_req, cpu_resume, irq_block}, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < NV; v++) begin
      automatic logic [14:0] row = VEC[v];
      automatic bit isrx = row[14];
      automatic int sel  = row[14] ? ((row[13:12] == 2'd3) ? 0 : int'(row[13:12])) : int'(row[11]);
      automatic string tag = $sformatf("vec%0d", v);
      cfg_src_rx = row[14]; cfg_rx_sel = row[13:12]; cfg_int_sel = row[11];
      cfg_wake_rst = row[10]; cfg_ext_osc = row[9];
      enter_sleep();
      cyc(1);
      chk(!reg_en && !osc_en && !pll_en && port_hold, {tag, " R1 sleep outputs"},
          {reg_en, osc_en, pll_en, port_hold}, 1);
      chk(irq_block, {tag, " R9 irq blocked in sleep"}, irq_block, 1);
      // every other pin low for a long time: no wake (R2)
      @(negedge clk);
      rx_pins = 3'b000; int_pins = 2'b00;
      if (isrx) rx_pins[sel] = 1'b1; else int_pins[sel] = 1'b1;
      cyc(20);
      rx_pins = 3'b111; int_pins = 2'b11;
      cyc(4);
      chk(!reg_en, {tag, " R2 other pins ignored"}, reg_en, 0);
      clear_mon();
      pin_low(isrx, sel, int'(row[7:0]));
      if (!row[8]) begin
        cyc(8);
        chk(!reg_en && irq_block, {tag, " R3 short pulse ignored"}, reg_en, 0);
        clear_mon();
        pin_low(isrx, sel, FILT + 3);
      end
      wait_run();
      cyc(2);
      check_seq(row[10], row[9], tag);
    end

    // R1 / collision: sleep request in the resume cycle is dropped
    cfg_src_rx = 1'b0; cfg_int_sel = 1'b0; cfg_wake_rst = 1'b0; cfg_ext_osc = 1'b0;
    enter_sleep();
    pin_low(1'b0, 0, FILT + 2);
    for (int i = 0; i < 1000 && !cpu_resume; i++) @(negedge clk);
    pd_req = 1'b1;
    @(negedge clk); pd_req = 1'b0;
    cyc(2);
    chk(reg_en && pll_en && !irq_block, "R1 request in resume cycle ignored",
        {reg_en, pll_en, irq_block}, 6);

    // R10: configuration changed while asleep has no effect
    cfg_src_rx = 1'b0; cfg_int_sel = 1'b1; cfg_wake_rst = 1'b0; cfg_ext_osc = 1'b0;
    enter_sleep();
    cfg_int_sel = 1'b0; cfg_wake_rst = 1'b1; cfg_ext_osc = 1'b1; cfg_src_rx = 1'b1;
    clear_mon();
    pin_low(1'b0, 0, 12);
    cyc(6);
    chk(!reg_en, "R10 new source not used", reg_en, 0);
    clear_mon();
    pin_low(1'b0, 1, FILT + 2);
    wait_run();
    cyc(2);
    check_seq(1'b0, 1'b0, "R10 captured cfg");

    // R11: hardware reset in the middle of the regulator wait
    cfg_src_rx = 1'b0; cfg_int_sel = 1'b0; cfg_wake_rst = 1'b1; cfg_ext_osc = 1'b0;
    enter_sleep();
    pin_low(1'b0, 0, FILT + 2);
    cyc(10);
    chk(irq_block && port_rst, "R11 sequence running before reset", {irq_block, port_rst}, 3);
    #2 rst_n = 1'b0;
    #1;
    chk(reg_en && osc_en && pll_en && !irq_block && !port_rst && !rst_req,
        "R11 async reset immediate", {reg_en, osc_en, pll_en, irq_block, port_rst, rst_req}, 56);
    cyc(2);
    rst_n = 1'b1;
    cyc(5);
    chk(!irq_block && reg_en, "R11 stays running after reset", irq_block, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule